// File: doc/BRIEF.md
# Iterative AES-128 Decryption Round Engine

This block recovers one 128-bit plaintext block from an AES-128 ciphertext. It has a single inverse-round datapath and uses it again on each clock cycle. The key schedule lives outside the block. The block walks that schedule from the last round key back to the first by driving a round-key index. The surrounding logic must return the selected 128-bit round key combinationally in the same cycle.

A start strobe, sampled while the engine is idle, captures the ciphertext. The block then runs three phases, one round per cycle:

- a first round: key XOR, then row unrotation, then inverse byte substitution;
- nine middle rounds: key XOR, then inverse column mixing, then unrotation, then inverse substitution;
- a closing key XOR with round key 0.

The result appears on the plaintext port together with a one-cycle completion pulse. The inverse substitution is computed in logic, not read from a table. Each byte goes through the inverse affine map and then a GF(2^8) inversion, done as a power chain.

Top module: `aes128DecIter`

## Requirements
- R1: After reset, `doneOut` is 0, `plainOut` is all zeros and `keyIdxOut` is 0; `keyIdxOut` stays 0 whenever the engine is idle.
- R2: A `startIn` sampled high while idle captures `cipherIn`. On the following cycle `keyIdxOut` reads 10. It then falls by exactly one per cycle until it reads 0.
- R3: The first round XORs the captured block with the key selected by index 10, then applies row unrotation and inverse substitution, with no column mixing.
- R4: Indices 9 down to 1 each perform, in this order: key XOR, inverse column mixing, row unrotation, inverse substitution.
- R5: At index 0 the state is XORed with the supplied key and the result is placed on `plainOut`. Ciphertext 69C4E0D86A7B0430D8CDB78070B4C55A under key 000102030405060708090A0B0C0D0E0F yields 00112233445566778899AABBCCDDEEFF.
- R6: State byte k occupies bits [127-8k -: 8] and sits at row k mod 4, column k div 4. Row unrotation leaves row 0 in place and rotates row r right by r columns.
- R7: Inverse substitution of a byte applies the inverse affine map (output bit i = b[i+2] ^ b[i+5] ^ b[i+7] ^ bit i of 0x05, indices mod 8) and then the multiplicative inverse in GF(2^8) modulo 0x11B, with 0 mapped to 0. Thus 0x00 maps to 0x52 and 0x01 maps to 0x09.
- R8: Inverse column mixing multiplies each column, row 0 first, by the circulant matrix whose first row is 0E 0B 0D 09.
- R9: `doneOut` is high for exactly one cycle, 11 clock edges after the edge that accepted `startIn`. `plainOut` keeps its value until the next completion.
- R10: A `startIn` that arrives while a block is in progress has no effect: the running block completes with its own result and no extra completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Begin decrypting `cipherIn` (honoured only when idle) |
| cipherIn | input | 128 | Ciphertext block, byte 0 in the top bits |
| roundKeyIn | input | 128 | Round key selected by `keyIdxOut`, returned in the same cycle |
| keyIdxOut | output | 4 | Index of the round key being consumed |
| plainOut | output | 128 | Recovered plaintext, held between completions |
| doneOut | output | 1 | One-cycle pulse when `plainOut` is updated |

## Verification
A fault in the index counter shows on `keyIdxOut` one cycle later. The same fault also moves or removes the completion pulse. A fault in the state register or in any round stage cannot be seen until completion. Because every stage diffuses across the whole block, it then corrupts most bytes of `plainOut` 11 cycles after start. A bad inverse substitution entry or a bad mixing coefficient therefore shows as a wrong plaintext, not as a timing error. For that reason the plaintext is compared against a known answer and against blocks produced by an independent forward cipher in the bench.

// File: rtl/aesDecPkg.sv
package aesDecPkg;

  typedef struct packed {
    logic loadCipher;
    logic firstRound;
    logic midRound;
    logic lastRound;
  } roundCtlT;

  function automatic logic [7:0] xtime(logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = '0;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // a^254 equals the multiplicative inverse (and maps 0 to 0)
  function automatic logic [7:0] gfInv(logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] res;
    sq  = a;
    res = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gfMul(sq, sq);
      res = gfMul(res, sq);
    end
    return res;
  endfunction

endpackage

// File: rtl/aesInvSbox.sv
module aesInvSbox (
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);
  import aesDecPkg::*;

  localparam logic [7:0] AFF_CONST = 8'h05;

  logic [7:0] unAffine;

  // inverse affine map first (R7)
  always_comb begin
    for (int i = 0; i < 8; i++) begin
      unAffine[i] = byteIn[(i + 2) % 8] ^ byteIn[(i + 5) % 8] ^
                    byteIn[(i + 7) % 8] ^ AFF_CONST[i];
    end
  end

  // then field inversion (R7)
  assign byteOut = gfInv(unAffine);

endmodule

// File: rtl/aesInvMixCol.sv
module aesInvMixCol (
  input  logic [31:0] colIn,
  output logic [31:0] colOut
);
  import aesDecPkg::*;

  logic [7:0] a [4];
  logic [7:0] m9 [4];
  logic [7:0] mB [4];
  logic [7:0] mD [4];
  logic [7:0] mE [4];

  // multiples 9, B, D, E from chained doubling (R8)
  for (genvar r = 0; r < 4; r++) begin : g_mul
    logic [7:0] x2, x4, x8;
    assign a[r]  = colIn[31 - 8*r -: 8];
    assign x2    = xtime(a[r]);
    assign x4    = xtime(x2);
    assign x8    = xtime(x4);
    assign m9[r] = x8 ^ a[r];
    assign mB[r] = x8 ^ x2 ^ a[r];
    assign mD[r] = x8 ^ x4 ^ a[r];
    assign mE[r] = x8 ^ x4 ^ x2;
  end

  assign colOut[31:24] = mE[0] ^ mB[1] ^ mD[2] ^ m9[3];
  assign colOut[23:16] = m9[0] ^ mE[1] ^ mB[2] ^ mD[3];
  assign colOut[15:8]  = mD[0] ^ m9[1] ^ mE[2] ^ mB[3];
  assign colOut[7:0]   = mB[0] ^ mD[1] ^ m9[2] ^ mE[3];

endmodule

// File: rtl/aesDecDatapath.sv
module aesDecDatapath #(
  parameter int BLOCK_BITS = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  aesDecPkg::roundCtlT      ctl,
  input  logic [BLOCK_BITS-1:0]    cipherIn,
  input  logic [BLOCK_BITS-1:0]    roundKeyIn,
  output logic [BLOCK_BITS-1:0]    plainOut
);
  localparam int NUM_BYTES = BLOCK_BITS / 8;
  localparam int NUM_COLS  = NUM_BYTES / 4;

  logic [BLOCK_BITS-1:0] stateQ;
  logic [BLOCK_BITS-1:0] plainQ;
  logic [BLOCK_BITS-1:0] keyed;
  logic [BLOCK_BITS-1:0] mixed;
  logic [BLOCK_BITS-1:0] mixSel;
  logic [BLOCK_BITS-1:0] shifted;
  logic [BLOCK_BITS-1:0] subbed;

  assign keyed = stateQ ^ roundKeyIn;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    aesInvMixCol u_mix (
      .colIn  (keyed[BLOCK_BITS-1-32*c -: 32]),
      .colOut (mixed[BLOCK_BITS-1-32*c -: 32])
    );
  end

  // column mixing only in the middle rounds (R3, R4)
  assign mixSel = ctl.midRound ? mixed : keyed;

  // row r rotated right by r columns (R6)
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_shc
    for (genvar r = 0; r < 4; r++) begin : g_shr
      assign shifted[BLOCK_BITS-1-8*(c*4+r) -: 8] =
        mixSel[BLOCK_BITS-1-8*((((c - r + NUM_COLS) % NUM_COLS) * 4) + r) -: 8];
    end
  end

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_sub
    aesInvSbox u_sbox (
      .byteIn  (shifted[BLOCK_BITS-1-8*k -: 8]),
      .byteOut (subbed[BLOCK_BITS-1-8*k -: 8])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
      plainQ <= '0;
    end else begin
      if (ctl.loadCipher)
        stateQ <= cipherIn;
      else if (ctl.firstRound || ctl.midRound)
        stateQ <= subbed;
      if (ctl.lastRound)
        plainQ <= keyed;
    end
  end

  assign plainOut = plainQ;

  // R9: plaintext only changes on a closing round
  a_r9_plain_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.lastRound |=> $stable(plainQ));

  // R2: control strobes are mutually exclusive
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadCipher, ctl.firstRound, ctl.midRound, ctl.lastRound}));

endmodule

// File: rtl/aesDecControl.sv
module aesDecControl #(
  parameter int ROUNDS = 10,
  localparam int IDX_W = $clog2(ROUNDS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  output aesDecPkg::roundCtlT  ctl,
  output logic [IDX_W-1:0]     keyIdx,
  output logic                 doneOut
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS);

  logic             busyQ;
  logic [IDX_W-1:0] idxQ;
  logic             doneQ;

  always_comb begin
    ctl.loadCipher = startIn && !busyQ;
    ctl.firstRound = busyQ && (idxQ == LAST_IDX);
    ctl.midRound   = busyQ && (idxQ != '0) && (idxQ != LAST_IDX);
    ctl.lastRound  = busyQ && (idxQ == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= ctl.lastRound;
      if (!busyQ) begin
        if (startIn) begin
          busyQ <= 1'b1;
          idxQ  <= LAST_IDX;
        end
      end else if (idxQ == '0) begin
        busyQ <= 1'b0;
      end else begin
        idxQ <= idxQ - 1'b1;
      end
    end
  end

  assign keyIdx  = idxQ;
  assign doneOut = doneQ;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  a_r9_done_follows_last: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lastRound |=> doneQ);

  a_r2_idx_steps: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && idxQ != '0) |=> (busyQ && idxQ == $past(idxQ) - 1'b1));

  a_r1_idle_idx_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> idxQ == '0);

  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && startIn && idxQ != '0) |=> (busyQ && idxQ != LAST_IDX));

endmodule

// File: rtl/aes128DecIter.sv
module aes128DecIter (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic [127:0] cipherIn,
  input  logic [127:0] roundKeyIn,
  output logic [3:0]   keyIdxOut,
  output logic [127:0] plainOut,
  output logic         doneOut
);
  import aesDecPkg::*;

  roundCtlT roundCtl;

  aesDecControl #(.ROUNDS(10)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .ctl     (roundCtl),
    .keyIdx  (keyIdxOut),
    .doneOut (doneOut)
  );

  aesDecDatapath #(.BLOCK_BITS(128)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (roundCtl),
    .cipherIn   (cipherIn),
    .roundKeyIn (roundKeyIn),
    .plainOut   (plainOut)
  );

endmodule

// File: tb/test_aes128DecIter.sv
module test_aes128DecIter;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [127:0] cipherIn = '0;
  logic [127:0] rkBus;
  logic [3:0]   keyIdxOut;
  logic [127:0] plainOut;
  logic         doneOut;

  logic [127:0] sched [0:10];
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rkBus = (keyIdxOut <= 4'd10) ? sched[keyIdxOut] : '0;

  aes128DecIter i_aes128DecIter (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cipherIn(cipherIn),
    .roundKeyIn(rkBus), .keyIdxOut(keyIdxOut), .plainOut(plainOut),
    .doneOut(doneOut)
  );

  // ---------------- independent forward model ----------------
  function automatic logic [7:0] bMul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= a;
      a = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] bInv(logic [7:0] a);
    if (a == 0) return 0;
    for (int x = 1; x < 256; x++)
      if (bMul(a, 8'(x)) == 8'h01) return 8'(x);
    return 0;
  endfunction

  function automatic logic [7:0] bSbox(logic [7:0] a);
    logic [7:0] v = bInv(a);
    logic [7:0] o;
    logic [7:0] c = 8'h63;
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
    return o;
  endfunction

  function automatic logic [127:0] bSub(logic [127:0] s);
    logic [127:0] o;
    for (int k = 0; k < 16; k++) o[127-8*k -: 8] = bSbox(s[127-8*k -: 8]);
    return o;
  endfunction

  function automatic logic [127:0] bShift(logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(c*4+r) -: 8] = s[127-8*(((c+r)%4)*4+r) -: 8];
    return o;
  endfunction

  function automatic logic [127:0] bMix(logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a0, a1, a2, a3;
      a0 = s[127-32*c -: 8];  a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];  a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = bMul(a0,2) ^ bMul(a1,3) ^ a2 ^ a3;
      o[119-32*c -: 8] = a0 ^ bMul(a1,2) ^ bMul(a2,3) ^ a3;
      o[111-32*c -: 8] = a0 ^ a1 ^ bMul(a2,2) ^ bMul(a3,3);
      o[103-32*c -: 8] = bMul(a0,3) ^ a1 ^ a2 ^ bMul(a3,2);
    end
    return o;
  endfunction

  task automatic keyExpand(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [7:0]  rcon = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {bSbox(t[31:24]), bSbox(t[23:16]), bSbox(t[15:8]), bSbox(t[7:0])};
        t ^= {rcon, 24'h0};
        rcon = bMul(rcon, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) sched[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] bEncrypt(logic [127:0] p);
    logic [127:0] s = p ^ sched[0];
    for (int r = 1; r < 10; r++) s = bMix(bShift(bSub(s))) ^ sched[r];
    return bShift(bSub(s)) ^ sched[10];
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // runs one block; optionally pokes a second start at cycle pokeAt
  task automatic runDecrypt(input logic [127:0] c, input int pokeAt, input logic [127:0] pokeC,
                            output logic [127:0] res, output int lat, output int nDone,
                            output bit idxOk);
    @(negedge clk);
    startIn = 1'b1; cipherIn = c;
    @(negedge clk);            // after the accepting edge
    startIn = 1'b0;
    idxOk = (keyIdxOut == 4'd10);
    lat = 0; nDone = 0; res = '0;
    for (int k = 1; k <= 16; k++) begin
      if (k == pokeAt) begin startIn = 1'b1; cipherIn = pokeC; end
      else startIn = 1'b0;
      @(negedge clk);
      if (k <= 10 && keyIdxOut != 4'(10 - k)) idxOk = 0;
      if (doneOut) begin
        nDone++;
        if (lat == 0) begin lat = k; res = plainOut; end
      end
    end
    startIn = 1'b0;
  endtask

  task automatic testReset();
    check("R1 done after reset", {127'd0, doneOut}, 128'd0);
    check("R1 plaintext after reset", plainOut, 128'd0);
    check("R1 index after reset", {124'd0, keyIdxOut}, 128'd0);
  endtask

  task automatic testKnownVector();
    logic [127:0] res; int lat, nd; bit ok;
    keyExpand(128'h000102030405060708090a0b0c0d0e0f);
    runDecrypt(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 0, '0, res, lat, nd, ok);
    // R3 R4 R5 R6 R7 R8: known answer
    check("R5 known answer", res, 128'h00112233445566778899aabbccddeeff);
    check("R2 index sequence", {127'd0, ok}, 128'd1);
    check("R9 latency", 128'(lat), 128'd11);
    check("R9 single pulse", 128'(nd), 128'd1);
    check("R1 idle index after run", {124'd0, keyIdxOut}, 128'd0);
  endtask

  task automatic testRoundTrip(input string tag, input logic [127:0] key, input logic [127:0] p);
    logic [127:0] res; int lat, nd; bit ok;
    keyExpand(key);
    runDecrypt(bEncrypt(p), 0, '0, res, lat, nd, ok);
    check({"R4 R7 R8 roundtrip ", tag}, res, p);
    check({"R9 latency ", tag}, 128'(lat), 128'd11);
  endtask

  task automatic testHold();
    logic [127:0 ] held = plainOut;
    for (int i = 0; i < 6; i++) @(negedge clk);
    check("R9 plaintext held", plainOut, held);
    check("R9 done low when idle", {127'd0, doneOut}, 128'd0);
  endtask

  task automatic testBusyIgnore();
    logic [127:0] res; int lat, nd; bit ok;
    logic [127:0] p1 = 128'h3243f6a8885a308d313198a2e0370734;
    keyExpand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    runDecrypt(bEncrypt(p1), 4, 128'hdeadbeef00112233445566778899aabb, res, lat, nd, ok);
    check("R10 result unaffected", res, p1);
    check("R10 single completion", 128'(nd), 128'd1);
    check("R10 latency unaffected", 128'(lat), 128'd11);
    check("R10 index sequence unaffected", {127'd0, ok}, 128'd1);
  endtask

  initial begin
    for (int r = 0; r < 11; r++) sched[r] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testKnownVector();
    testHold();
    testRoundTrip("zero", 128'h0, 128'h0);
    testRoundTrip("ones", {128{1'b1}}, {128{1'b1}});
    testRoundTrip("walk", 128'h0123456789abcdeffedcba9876543210, 128'h80000000000000000000000000000001);
    testRoundTrip("mixed", 128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a);
    testBusyIgnore();
    testHold();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule